// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block takes a byte stream of already-accepted Ethernet frames and stores each one in a circular region of local packet memory. The memory is addressed in 256-byte pages. Software programs four page numbers: the first page of the ring, the page one past its end, a guard page that marks how far the reader has consumed, and the page where the next frame lands. The writer drives a byte-wide memory write port. Each stored frame begins with a 4-byte header, and that header links to the page where the following frame will start.

When a frame starts, the writer checks that the ring is valid and that the device is running. It also checks that the distance from the landing page forward to the guard page can hold a maximum-size frame. If any check fails, the frame is refused. If all pass, the payload is written from byte 4 of the landing page onward, and the address wraps from the end page back to the first page. Frames shorter than the minimum are filled out with zeros. The header is written last, once the length is known. The landing page then moves to the linked page and a one-cycle completion pulse is raised.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset `cur_pg` is 0, `busy`, `mem_we`, `frame_done` and `frame_drop` are 0.
- R2: A frame start seen while `halt` is 1, or while `stop_pg` <= `start_pg`, raises `frame_drop` for one cycle. It writes no memory and leaves `cur_pg` unchanged.
- R3: Free pages are `bnd_pg - cur_pg` when `cur_pg < bnd_pg`, and `(stop_pg - start_pg) - (cur_pg - bnd_pg)` otherwise. A frame is refused (one-cycle `frame_drop`, no writes) when free pages times 256 is below 1518.
- R4: Payload byte k of an accepted frame is written in arrival order at the address 4 + k past the start of page `cur_pg`. Any address that reaches `stop_pg`*256 is replaced by `start_pg`*256. No write falls outside the ring.
- R5: A frame of fewer than 60 bytes is followed in memory by zero bytes until 60 bytes are stored.
- R6: Header bytes sit at offsets 0, 1, 2 and 3 of the landing page, in this order: status, next page, total length bits 7:0, total length bits 15:8. Total length is the stored length plus 4.
- R7: The status byte is 0x01, or 0x21 when bit 0 of the first frame byte is 1.
- R8: The next page is `cur_pg` + ceil((total + 4) / 256). If that is >= `stop_pg`, (`stop_pg` - `start_pg`) is subtracted.
- R9: The header is written after the whole payload and padding. In the cycle after the last header write, `cur_pg` holds the next page and `frame_done` is 1 for exactly one cycle.
- R10: A frame start seen while an earlier frame is still being stored, including its last header cycle, raises `frame_drop` for one cycle. That beat is not stored and the earlier frame completes unchanged. A start seen in the cycle `frame_done` is high is accepted at the updated `cur_pg`.
- R11: While idle, beats without `in_sof` write nothing and raise no pulse.
- R12: `cur_ld` loads `cur_ld_pg` into `cur_pg` on the next edge. A frame completion on the same edge takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt | input | 1 | Device stopped; new frames refused |
| start_pg | input | PG_W | First page of the ring |
| stop_pg | input | PG_W | Page one past the ring end |
| bnd_pg | input | PG_W | Guard page: reader position |
| cur_ld | input | 1 | Load strobe for the landing page |
| cur_ld_pg | input | PG_W | Value loaded by `cur_ld` |
| cur_pg | output | PG_W | Landing page of the next frame |
| in_valid | input | 1 | Byte beat valid |
| in_sof | input | 1 | Beat is first byte of a frame |
| in_eof | input | 1 | Beat is last byte of a frame |
| in_data | input | 8 | Frame byte |
| mem_we | output | 1 | Packet memory write enable |
| mem_addr | output | PG_W+PAGE_BITS | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| frame_done | output | 1 | One-cycle pulse: frame stored |
| frame_drop | output | 1 | One-cycle pulse: frame start refused |
| busy | output | 1 | A frame is being stored |

## Verification
Completion of one frame and refusal of the next frame can fall in the same cycle. This happens when a new start beat arrives exactly in the last header-write cycle. The bench counts four idle cycles after the last byte of a long frame and presents a lone start beat on that edge. It then requires that `frame_done` and `frame_drop` are both high in the following cycle. A further frame is driven in that same cycle, and its whole content must then appear at the freshly advanced landing page.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

   typedef enum logic [1:0] {
      RW_IDLE,
      RW_BODY,
      RW_FILL,
      RW_HEAD
   } rw_state_e;

   localparam logic [7:0] STAT_GOOD  = 8'h01;
   localparam logic [7:0] STAT_GROUP = 8'h20;
   localparam int         HEAD_BYTES = 4;
   localparam int         CRC_BYTES  = 4;

endpackage

// File: rtl/rxring_space.sv
module rxring_space #(
   parameter int PG_W       = 8,
   parameter int PAGE_BITS  = 8,
   parameter int NEED_BYTES = 1518
) (
   input  logic [PG_W-1:0] first_pg,
   input  logic [PG_W-1:0] end_pg,
   input  logic [PG_W-1:0] guard_pg,
   input  logic [PG_W-1:0] wr_pg,
   output logic            room_ok
);
   localparam int FW = PG_W + 1;
   localparam int BW = FW + PAGE_BITS;

   if (NEED_BYTES >= (1 << BW)) begin : g_bad_need
      $error("rxring_space: NEED_BYTES does not fit the page range");
   end

   logic [FW-1:0] span_pg;
   logic [FW-1:0] used_pg;
   logic [FW-1:0] free_pg;
   logic          short_neg;

   always_comb begin
      span_pg   = {1'b0, end_pg} - {1'b0, first_pg};
      used_pg   = '0;
      short_neg = 1'b0;
      if (wr_pg < guard_pg) begin
         free_pg = {1'b0, guard_pg} - {1'b0, wr_pg};
      end else begin
         used_pg   = {1'b0, wr_pg} - {1'b0, guard_pg};
         short_neg = (used_pg > span_pg);
         free_pg   = span_pg - used_pg;
      end
      room_ok = (end_pg > first_pg) && !short_neg &&
                ({free_pg, {PAGE_BITS{1'b0}}} >= BW'(NEED_BYTES));
   end
endmodule

// File: rtl/rxring_next.sv
module rxring_next
   import rxring_pkg::*;
#(
   parameter int PG_W      = 8,
   parameter int PAGE_BITS = 8,
   parameter int LEN_W     = 16
) (
   input  logic [PG_W-1:0]  base_pg,
   input  logic [PG_W-1:0]  first_pg,
   input  logic [PG_W-1:0]  end_pg,
   input  logic [LEN_W-1:0] total_len,
   output logic [PG_W-1:0]  next_pg
);
   localparam int NW    = ((LEN_W > PG_W) ? LEN_W : PG_W) + 2;
   localparam int ROUND = CRC_BYTES + (1 << PAGE_BITS) - 1;

   logic [NW-1:0] padded;
   logic [NW-1:0] span_pg;
   logic [NW-1:0] sum_pg;
   logic [NW-1:0] ring_pg;

   always_comb begin
      padded  = NW'(total_len) + NW'(ROUND);
      span_pg = padded >> PAGE_BITS;
      ring_pg = NW'(end_pg) - NW'(first_pg);
      sum_pg  = NW'(base_pg) + span_pg;
      if (sum_pg >= NW'(end_pg)) begin
         sum_pg = sum_pg - ring_pg;
      end
      next_pg = sum_pg[PG_W-1:0];
   end
endmodule

// File: rtl/rxring_step.sv
module rxring_step #(
   parameter int PG_W      = 8,
   parameter int PAGE_BITS = 8
) (
   input  logic [PG_W+PAGE_BITS-1:0] cur_addr,
   input  logic [PG_W-1:0]           first_pg,
   input  logic [PG_W-1:0]           end_pg,
   output logic [PG_W+PAGE_BITS-1:0] nxt_addr
);
   localparam int ADDR_W = PG_W + PAGE_BITS;

   logic [ADDR_W-1:0] plus1;
   logic [ADDR_W-1:0] end_addr;
   logic [ADDR_W-1:0] first_addr;

   assign plus1      = cur_addr + ADDR_W'(1);
   assign end_addr   = {end_pg, {PAGE_BITS{1'b0}}};
   assign first_addr = {first_pg, {PAGE_BITS{1'b0}}};
   assign nxt_addr   = (plus1 == end_addr) ? first_addr : plus1;
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
   import rxring_pkg::*;
#(
   parameter int PG_W      = 8,
   parameter int PAGE_BITS = 8,
   parameter int LEN_W     = 16,
   parameter int MAX_FRAME = 1514,
   parameter int MIN_FRAME = 60,
   parameter int RESET_PG  = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      halt,
   input  logic [PG_W-1:0]           start_pg,
   input  logic [PG_W-1:0]           stop_pg,
   input  logic [PG_W-1:0]           bnd_pg,
   input  logic                      cur_ld,
   input  logic [PG_W-1:0]           cur_ld_pg,
   output logic [PG_W-1:0]           cur_pg,
   input  logic                      in_valid,
   input  logic                      in_sof,
   input  logic                      in_eof,
   input  logic [7:0]                in_data,
   output logic                      mem_we,
   output logic [PG_W+PAGE_BITS-1:0] mem_addr,
   output logic [7:0]                mem_wdata,
   output logic                      frame_done,
   output logic                      frame_drop,
   output logic                      busy
);
   localparam int ADDR_W = PG_W + PAGE_BITS;
   localparam int NEED   = MAX_FRAME + HEAD_BYTES;

   // elaboration-time parameter checks
   if (PG_W < 2 || PG_W > 8) begin : g_bad_pg
      $error("rx_ring_writer: PG_W must lie in 2..8");
   end
   if (PAGE_BITS < 3) begin : g_bad_page
      $error("rx_ring_writer: PAGE_BITS must be at least 3");
   end
   if (LEN_W < 12 || LEN_W > 16) begin : g_bad_len
      $error("rx_ring_writer: LEN_W must lie in 12..16");
   end
   if (MIN_FRAME > MAX_FRAME || MAX_FRAME + 8 >= (1 << LEN_W)) begin : g_bad_frame
      $error("rx_ring_writer: frame limits inconsistent with LEN_W");
   end

   rw_state_e         state;
   logic [ADDR_W-1:0] wptr;
   logic [ADDR_W-1:0] wptr_nx;
   logic [PG_W-1:0]   base_pg;
   logic [PG_W-1:0]   next_pg;
   logic [PG_W-1:0]   cur_q;
   logic [LEN_W-1:0]  len_q;
   logic [LEN_W-1:0]  len_inc;
   logic [LEN_W-1:0]  total_len;
   logic [15:0]       tot16;
   logic              grp_q;
   logic [1:0]        hidx;
   logic              room_ok;
   logic              accept;
   logic              short_frame;
   logic              start_beat;
   logic [7:0]        head_byte;

   assign len_inc    = (state == RW_IDLE) ? LEN_W'(1) : len_q + LEN_W'(1);
   assign total_len  = len_q + LEN_W'(HEAD_BYTES);
   assign tot16      = 16'(total_len);
   assign accept     = room_ok && !halt;
   assign start_beat = in_valid && in_sof;
   assign busy       = (state != RW_IDLE);
   assign cur_pg     = cur_q;

   // minimum-length fill: present only when a minimum is configured
   if (MIN_FRAME > 0) begin : g_pad
      assign short_frame = (len_inc < LEN_W'(MIN_FRAME));
   end else begin : g_nopad
      assign short_frame = 1'b0;
   end

   always_comb begin
      case (hidx)
         2'd0:    head_byte = STAT_GOOD | (grp_q ? STAT_GROUP : 8'h00);
         2'd1:    head_byte = 8'(next_pg);
         2'd2:    head_byte = tot16[7:0];
         default: head_byte = tot16[15:8];
      endcase
   end

   rxring_space #(
      .PG_W      (PG_W),
      .PAGE_BITS (PAGE_BITS),
      .NEED_BYTES(NEED)
   ) u_space (
      .first_pg(start_pg),
      .end_pg  (stop_pg),
      .guard_pg(bnd_pg),
      .wr_pg   (cur_q),
      .room_ok (room_ok)
   );

   rxring_next #(
      .PG_W     (PG_W),
      .PAGE_BITS(PAGE_BITS),
      .LEN_W    (LEN_W)
   ) u_next (
      .base_pg  (base_pg),
      .first_pg (start_pg),
      .end_pg   (stop_pg),
      .total_len(total_len),
      .next_pg  (next_pg)
   );

   rxring_step #(
      .PG_W     (PG_W),
      .PAGE_BITS(PAGE_BITS)
   ) u_step (
      .cur_addr(wptr),
      .first_pg(start_pg),
      .end_pg  (stop_pg),
      .nxt_addr(wptr_nx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= RW_IDLE;
         wptr       <= '0;
         base_pg    <= '0;
         cur_q      <= PG_W'(RESET_PG);
         len_q      <= '0;
         grp_q      <= 1'b0;
         hidx       <= 2'd0;
         mem_we     <= 1'b0;
         mem_addr   <= '0;
         mem_wdata  <= '0;
         frame_done <= 1'b0;
         frame_drop <= 1'b0;
      end else begin
         mem_we     <= 1'b0;
         frame_done <= 1'b0;
         frame_drop <= 1'b0;
         if (cur_ld) begin
            cur_q <= cur_ld_pg;
         end
         unique case (state)
            RW_IDLE: begin
               if (start_beat) begin
                  if (accept) begin
                     base_pg   <= cur_q;
                     mem_we    <= 1'b1;
                     mem_addr  <= {cur_q, PAGE_BITS'(HEAD_BYTES)};
                     mem_wdata <= in_data;
                     wptr      <= {cur_q, PAGE_BITS'(HEAD_BYTES + 1)};
                     len_q     <= len_inc;
                     grp_q     <= in_data[0];
                     hidx      <= 2'd0;
                     if (in_eof) begin
                        state <= short_frame ? RW_FILL : RW_HEAD;
                     end else begin
                        state <= RW_BODY;
                     end
                  end else begin
                     frame_drop <= 1'b1;
                  end
               end
            end
            RW_BODY: begin
               if (in_valid) begin
                  if (in_sof) begin
                     frame_drop <= 1'b1;
                  end else begin
                     mem_we    <= 1'b1;
                     mem_addr  <= wptr;
                     mem_wdata <= in_data;
                     wptr      <= wptr_nx;
                     len_q     <= len_inc;
                     if (in_eof) begin
                        state <= short_frame ? RW_FILL : RW_HEAD;
                     end
                  end
               end
            end
            RW_FILL: begin
               frame_drop <= start_beat;
               mem_we     <= 1'b1;
               mem_addr   <= wptr;
               mem_wdata  <= 8'h00;
               wptr       <= wptr_nx;
               len_q      <= len_inc;
               if (!short_frame) begin
                  state <= RW_HEAD;
               end
            end
            RW_HEAD: begin
               frame_drop <= start_beat;
               mem_we     <= 1'b1;
               mem_addr   <= {base_pg, PAGE_BITS'(hidx)};
               mem_wdata  <= head_byte;
               hidx       <= hidx + 2'd1;
               if (hidx == 2'd3) begin
                  cur_q      <= next_pg;
                  frame_done <= 1'b1;
                  state      <= RW_IDLE;
               end
            end
            default: state <= RW_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rx_ring_writer_chk.sv
module rx_ring_writer_chk #(
   parameter int PG_W      = 8,
   parameter int PAGE_BITS = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      halt,
   input logic [PG_W-1:0]           start_pg,
   input logic [PG_W-1:0]           stop_pg,
   input logic                      cur_ld,
   input logic [PG_W-1:0]           cur_pg,
   input logic                      in_valid,
   input logic                      in_sof,
   input logic                      mem_we,
   input logic [PG_W+PAGE_BITS-1:0] mem_addr,
   input logic                      frame_done,
   input logic                      frame_drop,
   input logic                      busy
);
   localparam int ADDR_W = PG_W + PAGE_BITS;

   logic [PG_W-1:0] wr_page;
   assign wr_page = mem_addr[ADDR_W-1:PAGE_BITS];

   // R4
   wr_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (wr_page >= start_pg && wr_page < stop_pg));

   // R2
   refuse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && in_valid && in_sof && (halt || stop_pg <= start_pg))
      |=> (!busy && !mem_we));

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   // R9
   done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> $past(busy));

   // R8
   done_pg_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (cur_pg >= start_pg && cur_pg < stop_pg));

   // R12
   cur_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_done && !$past(cur_ld)) |-> $stable(cur_pg));

   // R10
   drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_drop |-> $past(in_valid && in_sof));
endmodule

bind rx_ring_writer rx_ring_writer_chk #(
   .PG_W     (PG_W),
   .PAGE_BITS(PAGE_BITS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .halt      (halt),
   .start_pg  (start_pg),
   .stop_pg   (stop_pg),
   .cur_ld    (cur_ld),
   .cur_pg    (cur_pg),
   .in_valid  (in_valid),
   .in_sof    (in_sof),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .frame_done(frame_done),
   .frame_drop(frame_drop),
   .busy      (busy)
);

// File: tb/rx_ring_writer_test.sv
module rx_ring_writer_test;
   localparam int CLK_PERIOD = 10;
   localparam int MEM_SZ     = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cur_ld = 1'b0;
   logic [7:0]  cur_ld_pg = 8'h00;
   logic        in_valid = 1'b0;
   logic        in_sof = 1'b0;
   logic        in_eof = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic [7:0]  start_pg, stop_pg, bnd_pg, cur_pg;
   logic        halt;
   logic        mem_we, frame_done, frame_drop, busy;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;

   int m_start = 2;
   int m_stop  = 10;
   int m_bnd   = 2;
   int m_cur   = 0;
   bit m_halt  = 1'b0;

   int checks = 0;
   int fails  = 0;
   int done_cnt = 0;
   int drop_cnt = 0;
   int oob_cnt  = 0;
   bit finished = 1'b0;

   logic [7:0] bmem [0:MEM_SZ-1] = '{default: 8'h00};
   logic [7:0] emem [0:MEM_SZ-1] = '{default: 8'h00};

   assign start_pg = 8'(m_start);
   assign stop_pg  = 8'(m_stop);
   assign bnd_pg   = 8'(m_bnd);
   assign halt     = m_halt;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_ring_writer uut (
      .clk(clk), .rst_n(rst_n), .halt(halt),
      .start_pg(start_pg), .stop_pg(stop_pg), .bnd_pg(bnd_pg),
      .cur_ld(cur_ld), .cur_ld_pg(cur_ld_pg), .cur_pg(cur_pg),
      .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .frame_done(frame_done), .frame_drop(frame_drop), .busy(busy)
   );

   // observed memory and pulse counters, sampled away from the clock edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_we) begin
            if (mem_addr < 16'(MEM_SZ)) bmem[mem_addr[11:0]] = mem_wdata;
            else oob_cnt++;
         end
         if (frame_done) done_cnt++;
         if (frame_drop) drop_cnt++;
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   function automatic logic [7:0] byte_at(input int i, input logic [7:0] b0, input logic [7:0] seed);
      return (i == 0) ? b0 : 8'(int'(seed) + i * 7);
   endfunction

   function automatic bit model_accept();
      int fr;
      if (m_halt || m_stop <= m_start) return 1'b0;
      if (m_cur < m_bnd) fr = m_bnd - m_cur;
      else fr = (m_stop - m_start) - (m_cur - m_bnd);
      return (fr * 256 >= 1518);
   endfunction

   task automatic model_store(input int n, input logic [7:0] b0, input logic [7:0] seed);
      int base, a, stored, total, span, nx;
      base = m_cur * 256;
      a = base + 4;
      stored = (n < 60) ? 60 : n;
      for (int i = 0; i < stored; i++) begin
         emem[a] = (i < n) ? byte_at(i, b0, seed) : 8'h00;
         a++;
         if (a == m_stop * 256) a = m_start * 256;
      end
      total = stored + 4;
      span = (total + 4 + 255) / 256;
      nx = m_cur + span;
      if (nx >= m_stop) nx -= (m_stop - m_start);
      emem[base]     = b0[0] ? 8'h21 : 8'h01;
      emem[base + 1] = 8'(nx);
      emem[base + 2] = 8'(total & 255);
      emem[base + 3] = 8'(total >> 8);
      m_cur = nx;
   endtask

   // drives one frame, beginning at the current negedge
   task automatic push(input int n, input logic [7:0] b0, input logic [7:0] seed);
      for (int i = 0; i < n; i++) begin
         in_valid = 1'b1;
         in_sof   = (i == 0);
         in_eof   = (i == n - 1);
         in_data  = byte_at(i, b0, seed);
         @(negedge clk);
      end
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
   endtask

   task automatic mem_cmp(input string tag);
      int bad = 0, first = -1;
      for (int i = 0; i < MEM_SZ; i++) begin
         if (bmem[i] !== emem[i]) begin
            bad++;
            if (first < 0) first = i;
         end
      end
      chk(bad == 0, tag, bad, 0);
      if (bad != 0)
         $display("  first mismatch at %0d: got %0h want %0h", first, bmem[first], emem[first]);
   endtask

   task automatic load_cur(input int pg);
      @(negedge clk);
      cur_ld = 1'b1; cur_ld_pg = 8'(pg);
      @(negedge clk);
      cur_ld = 1'b0;
      m_cur = pg;
   endtask

   task automatic do_frame(input int n, input logic [7:0] b0, input logic [7:0] seed, input string tag);
      bit acc;
      int d0, p0;
      acc = model_accept();
      d0 = done_cnt; p0 = drop_cnt;
      if (acc) model_store(n, b0, seed);
      @(negedge clk);
      push(n, b0, seed);
      repeat (72) @(negedge clk);
      chk(done_cnt - d0 == (acc ? 1 : 0), {tag, " done count"}, done_cnt - d0, acc ? 1 : 0);
      chk(drop_cnt - p0 == (acc ? 0 : 1), {tag, " drop count"}, drop_cnt - p0, acc ? 0 : 1);
      chk(cur_pg === 8'(m_cur), {tag, " cur_pg"}, int'(cur_pg), m_cur);
      mem_cmp({tag, " memory"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         report();
         $finish;
      end
   end

   initial begin
      int d0, p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cur_pg === 8'h00, "R1 cur_pg", int'(cur_pg), 0);
      chk(busy === 1'b0 && mem_we === 1'b0, "R1 busy/mem_we", int'({busy, mem_we}), 0);
      chk(frame_done === 1'b0 && frame_drop === 1'b0, "R1 pulses", int'({frame_done, frame_drop}), 0);

      // R12 landing page load
      load_cur(2);
      chk(cur_pg === 8'd2, "R12 cur load", int'(cur_pg), 2);

      // R11 beats without a start are ignored while idle
      d0 = done_cnt; p0 = drop_cnt;
      @(negedge clk);
      for (int i = 0; i < 5; i++) begin
         in_valid = 1'b1; in_sof = 1'b0; in_eof = (i == 4); in_data = 8'(i + 1);
         @(negedge clk);
      end
      in_valid = 1'b0; in_eof = 1'b0;
      repeat (4) @(negedge clk);
      chk(done_cnt == d0 && drop_cnt == p0, "R11 no pulses", done_cnt - d0 + drop_cnt - p0, 0);
      chk(busy === 1'b0, "R11 idle", int'(busy), 0);
      mem_cmp("R11 memory untouched");

      // R4 R6 R7 R8 R9 basic frames
      m_bnd = m_cur;
      do_frame(100, 8'h10, 8'h33, "R4 R6 R8 R9 frame100");
      do_frame(20, 8'h42, 8'h05, "R5 short frame");
      m_bnd = m_cur;
      do_frame(64, 8'h01, 8'h77, "R7 group bit");

      // near-exhaustive length sweep, ring reopened before each frame
      for (int n = 1; n <= 70; n++) begin
         m_bnd = m_cur;
         do_frame(n, 8'(n * 3), 8'(n), "R4 R5 R6 R8 sweep");
      end
      begin
         int sizes[8] = '{200, 251, 252, 255, 256, 508, 1000, 1514};
         foreach (sizes[k]) begin
            m_bnd = m_cur;
            do_frame(sizes[k], 8'(k * 2 + 1), 8'(k + 9), "R4 R6 R8 large wrap");
         end
      end

      // R3 free space threshold, both arms of the rule
      load_cur(3); m_bnd = 9;
      do_frame(60, 8'h02, 8'h11, "R3 six pages below guard");
      load_cur(3); m_bnd = 8;
      do_frame(60, 8'h02, 8'h12, "R3 five pages below guard");
      load_cur(8); m_bnd = 2;
      do_frame(60, 8'h02, 8'h13, "R3 wrapped two pages");
      load_cur(7); m_bnd = 5;
      do_frame(60, 8'h02, 8'h14, "R3 wrapped six pages");

      // R2 halted device and invalid ring
      m_bnd = m_cur; m_halt = 1'b1;
      do_frame(80, 8'h00, 8'h21, "R2 halted");
      m_halt = 1'b0; m_start = 5; m_stop = 5;
      do_frame(80, 8'h00, 8'h22, "R2 stop equals start");
      m_start = 9; m_stop = 4;
      do_frame(80, 8'h00, 8'h23, "R2 stop below start");
      m_start = 2; m_stop = 10;
      load_cur(4); m_bnd = 4;

      // R10 start in last header cycle, then start in the completion cycle
      d0 = done_cnt; p0 = drop_cnt;
      model_store(100, 8'h06, 8'h50);
      @(negedge clk);
      push(100, 8'h06, 8'h50);
      repeat (3) @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1; in_data = 8'hEE;
      @(negedge clk);
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
      chk(frame_done === 1'b1 && frame_drop === 1'b1, "R10 done and drop same cycle",
          int'({frame_done, frame_drop}), 3);
      chk(cur_pg === 8'(m_cur), "R10 cur advanced at done", int'(cur_pg), m_cur);
      model_store(80, 8'h08, 8'h60);
      push(80, 8'h08, 8'h60);
      repeat (72) @(negedge clk);
      chk(done_cnt - d0 == 2, "R10 done count", done_cnt - d0, 2);
      chk(drop_cnt - p0 == 1, "R10 drop count", drop_cnt - p0, 1);
      chk(cur_pg === 8'(m_cur), "R10 cur_pg", int'(cur_pg), m_cur);
      mem_cmp("R10 memory");

      chk(oob_cnt == 0, "R4 writes outside memory window", oob_cnt, 0);

      finished = 1'b1;
      report();
      $finish;
   end
endmodule